// File: doc/BRIEF.md
# Packed Signed Rounding Variable Shifter

This block takes a packed vector of signed elements and a second packed vector of the same width that holds one shift amount per element. It shifts each element by its own amount and registers the packed result. A run-time 2-bit size code splits the vector into lanes of 8, 16, 32 or 64 bits. An amount of zero or more gives a left shift, and the result is cut to the lane width with no saturation. A negative amount gives an arithmetic right shift by the magnitude, rounded to nearest, with exact halves rounding toward plus infinity.

Each amount is read as a signed value of the full lane width. Before the shift, the amount is clamped to plus or minus (lane width + 1). Very large amounts in either direction therefore flush the lane to zero. There is no per-lane enable, so every lane of the result is written on every cycle. The vector width is a parameter and must be a multiple of 64.

Top module: `vrs_shift_top`

## Requirements
- R1: The size code sets the lane width to 8 << size_i: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane k occupies bits [k*w +: w], with lane 0 in the least significant bits. Each lane uses only its own element and its own amount.
- R2: res_o is registered. A result appears on the first rising clock edge after its inputs are applied. While rst_n is low (asynchronous, active low), res_o is zero.
- R3: For an amount a with 0 <= a < w, the lane result is the element shifted left by a, keeping only the low w bits. An amount of zero returns the element unchanged.
- R4: For an amount of w or more, the lane result is zero.
- R5: For an amount -n with 1 <= n <= w, the lane result is floor((element + 2^(n-1)) / 2^n), kept to w bits. Exact halves round toward plus infinity, so 3 with amount -1 gives 2 and -3 with amount -1 gives -1.
- R6: For an amount of -(w+1) or less, the lane result is zero for every element, including the most negative one.
- R7: The rounding addition cannot overflow. The largest positive element with amount -1 gives 2^(w-2); for example, 127 in an 8-bit lane gives 64.
- R8: The amount is read as a signed w-bit value. In a 16-bit lane, 0x8000 is -32768, so it flushes the lane to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_i | input | 2 | Lane width code (8 << size_i bits) |
| data_i | input | VEC_W | Packed signed elements |
| amt_i | input | VEC_W | Packed signed per-lane shift amounts |
| res_o | output | VEC_W | Packed shifted result, registered |

## Verification
The bench builds the block with VEC_W set to 64. This gives eight byte lanes per vector, so every pair of 8-bit element and 8-bit amount (all 65536 of them) can be swept in 8192 vectors. The same 64-bit width holds four, two or one lane for the wider sizes. These get pseudo-random elements with amounts drawn around the clamp bounds, plus directed edges: ±w, ±(w+1), the most negative element and exact half ties. All of it is compared against an arithmetic model on 128-bit integers.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } lane_size_e;

    localparam int NUM_SIZES = 4;
    localparam int MIN_LANE_W = 8;
    localparam int MAX_LANE_W = MIN_LANE_W << (NUM_SIZES - 1);
    // magnitude of a clamped amount never exceeds MAX_LANE_W+1
    localparam int MAG_W = $clog2(MAX_LANE_W + 2) + 1;
endpackage

// File: rtl/vrs_lane.sv
module vrs_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] elem_i,
    input  logic [W-1:0] amt_i,
    output logic [W-1:0] res_o
);
    import vrs_pkg::*;

    localparam int XW = W + 2;
    localparam logic signed [W-1:0] LIM = W'(W + 1);

    logic signed [W-1:0]  amt_s;
    logic signed [W-1:0]  clamp;
    logic [MAG_W-1:0]     mag;
    logic signed [XW-1:0] ext;
    logic signed [XW-1:0] rnd;
    logic signed [XW-1:0] sum;

    always_comb begin
        amt_s = $signed(amt_i);
        if (amt_s > LIM) begin
            clamp = LIM;
        end else if (amt_s < -LIM) begin
            clamp = -LIM;
        end else begin
            clamp = amt_s;
        end

        ext = {{2{elem_i[W-1]}}, elem_i};
        rnd = '0;
        sum = '0;
        mag = '0;
        if (!clamp[W-1]) begin
            mag   = MAG_W'(clamp);
            res_o = elem_i << mag;
        end else begin
            mag   = MAG_W'(-clamp);
            rnd   = {{(XW-1){1'b0}}, 1'b1} << (mag - MAG_W'(1));
            sum   = ext + rnd;
            res_o = W'(sum >>> mag);
        end
    end
endmodule

// File: rtl/vrs_lane_array.sv
module vrs_lane_array #(
    parameter int VEC_W = 128,
    parameter int W     = 8
) (
    input  logic [VEC_W-1:0] data_i,
    input  logic [VEC_W-1:0] amt_i,
    output logic [VEC_W-1:0] res_o
);
    localparam int LANES = VEC_W / W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        vrs_lane #(.W(W)) u_lane (
            .elem_i (data_i[k*W +: W]),
            .amt_i  (amt_i[k*W +: W]),
            .res_o  (res_o[k*W +: W])
        );
    end
endmodule

// File: rtl/vrs_shift_top.sv
module vrs_shift_top #(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       size_i,
    input  logic [VEC_W-1:0] data_i,
    input  logic [VEC_W-1:0] amt_i,
    output logic [VEC_W-1:0] res_o
);
    import vrs_pkg::*;

    if (VEC_W % MAX_LANE_W != 0 || VEC_W == 0) begin : g_bad_width
        $error("VEC_W must be a non-zero multiple of 64");
    end

    typedef struct packed {
        logic [VEC_W-1:0] res;
    } stage_t;

    logic [VEC_W-1:0] cand [NUM_SIZES];
    stage_t           st_d;
    stage_t           st_q;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        vrs_lane_array #(
            .VEC_W (VEC_W),
            .W     (MIN_LANE_W << s)
        ) u_arr (
            .data_i (data_i),
            .amt_i  (amt_i),
            .res_o  (cand[s])
        );
    end

    always_comb begin
        st_d = st_q;
        unique case (lane_size_e'(size_i))
            SZ_8:    st_d.res = cand[0];
            SZ_16:   st_d.res = cand[1];
            SZ_32:   st_d.res = cand[2];
            default: st_d.res = cand[3];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o = st_q.res;
endmodule

// File: rtl/vrs_checks.sv
module vrs_checks #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       size_i,
    input logic [VEC_W-1:0] data_i,
    input logic [VEC_W-1:0] amt_i,
    input logic [VEC_W-1:0] res_o
);
    // R2: held in reset means zero output on the following edge
    a_r2_reset_clear: assert property (@(posedge clk)
        !rst_n |=> res_o == '0);

    // R3: all-zero amounts pass the elements through after one cycle
    a_r3_zero_identity: assert property (@(posedge clk) disable iff (!rst_n)
        amt_i == '0 |=> res_o == $past(data_i));

    // R4: 64-bit lane 0 shifted left by 64 or more becomes zero
    a_r4_left_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd3 && !amt_i[63] && amt_i[62:0] >= 63'd64) |=> res_o[63:0] == 64'd0);

    // R6: 64-bit lane 0 shifted right by 65 or more becomes zero
    a_r6_right_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd3 && $signed(amt_i[63:0]) <= -64'sd65) |=> res_o[63:0] == 64'd0);
endmodule

bind vrs_shift_top vrs_checks #(.VEC_W(VEC_W)) u_checks (.*);

// File: tb/vrs_shift_top_test.sv
module vrs_shift_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 64;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    size_i = '0;
    logic [VW-1:0] data_i = '0;
    logic [VW-1:0] amt_i = '0;
    logic [VW-1:0] res_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    vrs_shift_top #(.VEC_W(VW)) uut (
        .clk(clk), .rst_n(rst_n), .size_i(size_i),
        .data_i(data_i), .amt_i(amt_i), .res_o(res_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] lmask(int w);
        return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic signed [127:0] sext(int w, logic [63:0] v);
        logic signed [127:0] r;
        r = {64'd0, v & lmask(w)};
        if (v[w-1]) r = r - (128'sd1 <<< w);
        return r;
    endfunction

    function automatic logic signed [127:0] clamp_amt(int w, logic [63:0] a);
        logic signed [127:0] sa, lim;
        sa  = sext(w, a);
        lim = 128'(w + 1);
        if (sa > lim) sa = lim;
        else if (sa < -lim) sa = -lim;
        return sa;
    endfunction

    function automatic logic [63:0] model(int w, logic [63:0] e, logic [63:0] a);
        logic signed [127:0] se, sa, r;
        int n;
        se = sext(w, e);
        sa = clamp_amt(w, a);
        if (sa >= 0) begin
            r = se <<< int'(sa);
        end else begin
            n = int'(-sa);
            r = (se + (128'sd1 <<< (n - 1))) >>> n;
        end
        return r[63:0] & lmask(w);
    endfunction

    function automatic string tag_of(int w, logic [63:0] a);
        logic signed [127:0] sa;
        sa = clamp_amt(w, a);
        if (sa >= 0 && sa < w) return "R3";
        if (sa >= w) return "R4";
        if (sa >= -w) return "R5";
        return "R6";
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive one vector, compare every lane one clock later
    task automatic run_vec(int s, logic [63:0] d, logic [63:0] a);
        int w;
        int lanes;
        logic [63:0] m;
        w = 8 << s;
        lanes = VW / w;
        m = lmask(w);
        @(negedge clk);
        size_i = 2'(s);
        data_i = d;
        amt_i  = a;
        @(negedge clk);
        for (int k = 0; k < lanes; k++) begin
            chk(tag_of(w, (a >> (k*w)) & m),
                (res_o >> (k*w)) & m,
                model(w, (d >> (k*w)) & m, (a >> (k*w)) & m));
        end
    endtask

    task automatic run_direct(string tag, int s, logic [63:0] d, logic [63:0] a, logic [63:0] exp);
        @(negedge clk);
        size_i = 2'(s);
        data_i = d;
        amt_i  = a;
        @(negedge clk);
        chk(tag, res_o, exp);
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        data_i = 64'hDEAD_BEEF_0123_4567;
        amt_i  = 64'h0101_0101_0101_0101;
        repeat (3) @(negedge clk);
        chk("R2 reset", res_o, 64'd0);
        rst_n = 1'b1;
        chk("R2 after release", res_o, 64'd0);

        // R1: lane packing, only lane 3 gets a shift of one
        run_direct("R1 packing", 0, 64'h0807_0605_0403_0201,
                   64'h0000_0000_0100_0000, 64'h0807_0605_0803_0201);
        // R1: 16-bit lanes, lane 1 shifted left by 4, others unchanged
        run_direct("R1 16-bit lanes", 1, 64'h0004_0003_0002_0001,
                   64'h0000_0000_0004_0000, 64'h0004_0003_0020_0001);
        // R5 ties toward +inf: 3>>1 -> 2 (lane0), -3>>1 -> -1 (lane1)
        run_direct("R5 ties", 0, 64'h0000_0000_0000_FD03,
                   64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_FF02);
        // R7: largest positive byte with amount -1 gives 64
        run_direct("R7 byte max", 0, 64'h0000_0000_0000_007F,
                   64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0040);
        // R7: largest positive 64-bit element with amount -1 gives 2^62
        run_direct("R7 dword max", 3, 64'h7FFF_FFFF_FFFF_FFFF,
                   64'hFFFF_FFFF_FFFF_FFFF, 64'h4000_0000_0000_0000);
        // R8: 16-bit amount 0x8000 is negative, flushes lane to zero
        run_direct("R8 signed amount", 1, 64'h0000_0000_0000_7FFF,
                   64'h0000_0000_0000_8000, 64'd0);
        // R6: most negative 32-bit element, amount -33 gives zero
        run_direct("R6 min elem", 2, 64'h0000_0000_8000_0000,
                   64'h0000_0000_FFFF_FFDF, 64'd0);
        // R4: 64-bit amount 64 gives zero
        run_direct("R4 dword", 3, 64'h0000_0000_0000_0001, 64'd64, 64'd0);

        // exhaustive 8-bit sweep over every element and amount
        for (int e = 0; e < 256; e++) begin
            for (int ab = 0; ab < 256; ab += 8) begin
                logic [63:0] d, a;
                d = '0;
                a = '0;
                for (int k = 0; k < 8; k++) begin
                    d |= 64'(e) << (k*8);
                    a |= 64'((ab + k) & 255) << (k*8);
                end
                run_vec(0, d, a);
            end
        end

        // wider lanes: edge amounts on edge elements
        for (int s = 1; s < 4; s++) begin
            int w;
            int lanes;
            logic [63:0] m;
            w = 8 << s;
            lanes = VW / w;
            m = lmask(w);
            for (int ei = 0; ei < 6; ei++) begin
                for (int ai = 0; ai < 8; ai++) begin
                    logic [63:0] ev, d, a;
                    int av;
                    case (ei)
                        0: ev = 64'd1 << (w - 1);
                        1: ev = (64'd1 << (w - 1)) - 64'd1;
                        2: ev = m;
                        3: ev = 64'd3;
                        4: ev = (-64'd3) & m;
                        default: ev = 64'd1 << (w - 2);
                    endcase
                    case (ai)
                        0: av = w;
                        1: av = w + 1;
                        2: av = -w;
                        3: av = -(w + 1);
                        4: av = -1;
                        5: av = w - 1;
                        6: av = -(w - 1);
                        default: av = 0;
                    endcase
                    d = '0;
                    a = '0;
                    for (int k = 0; k < lanes; k++) begin
                        d |= (ev & m) << (k*w);
                        a |= (64'(av + k) & m) << (k*w);
                    end
                    run_vec(s, d, a);
                end
            end
        end

        // wider lanes: pseudo-random data, amounts near the clamp bounds
        for (int s = 1; s < 4; s++) begin
            int w;
            int lanes;
            logic [63:0] m;
            w = 8 << s;
            lanes = VW / w;
            m = lmask(w);
            for (int n = 0; n < 2000; n++) begin
                logic [63:0] d, a;
                d = {$urandom(), $urandom()};
                a = '0;
                for (int k = 0; k < lanes; k++) begin
                    logic [63:0] lv;
                    if ((n + k) % 5 == 0) lv = {$urandom(), $urandom()} & m;
                    else lv = 64'($signed($urandom_range(0, 2*w + 8)) - (w + 4)) & m;
                    a |= lv << (k*w);
                end
                run_vec(s, d, a);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule